// File: doc/BRIEF.md
# Vector Element Address Sequencer

This block turns one vector load or store request into a stream of effective addresses, one for each element. When the start strobe is sampled, the block captures the base value, a displacement, the access size, the vector length, the stride mode, the shift amount and an index-ordering flag. It then presents addresses on a valid/ready output. Each address carries a tag with the logical element number. A done pulse marks the end of the stream. The load/store pipeline downstream consumes the addresses at its own pace.

The block has three stride modes. Unit stride steps by the access size. Element stride steps by the displacement itself. Shifted mode scales the displacement by the access size and the element position, then shifts the product left. Any mode can replace the element position with its bit-reversed value over log2(VL) bits. This gives the butterfly ordering used by radix-2 transforms. The block refuses bit reversal when VL is not a power of two. All address arithmetic is 64-bit and wraps.

Top module: `vec_ea_seq`

## Requirements
- R1: With mode 2'b00 (unit stride), element i has address B + sext(D) + S*i. B is the base term, D is the 16-bit signed displacement and S is the access size in bytes.
- R2: With mode 2'b01 and with `base_scalar_i`=1 and D≠0 together, element i has address B + sext(D)*i. If either condition is not met, the block uses the unit-stride rule of R1. Mode 2'b11 also uses the unit-stride rule.
- R3: When `base_zero_i`=1, the base term B is 0 whatever `base_i` holds. Otherwise B equals `base_i`.
- R4: With mode 2'b10 (shifted), element i has address B + ((sext(D)*S*i) << `shift_i`).
- R5: When `bitrev_i`=1 and VL is a power of two, the position i in R1, R2 and R4 is the element number reversed over log2(VL) bits. For VL=4 the position order is 0,2,1,3.
- R6: When `bitrev_i`=1 and VL is non-zero but not a power of two, `err_o` pulses in the cycle after start. No address and no done are produced.
- R7: Addresses appear from the cycle after start. `addr_idx_o` runs 0..VL-1 in order. An address and its tag stay stable while valid is high and ready is low. Valid stays low outside a sequence, including after reset.
- R8: `done_o` is high in the same cycle as the handshake of the last element, and at no other time during a sequence.
- R9: When VL=0, `done_o` pulses in the cycle after start and no address is emitted.
- R10: A start strobe is ignored while a sequence is running. The running sequence keeps its captured operands.
- R11: Addresses wrap modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a sequence (sampled only when idle) |
| base_i | input | 64 | Base register value |
| base_zero_i | input | 1 | Base field is zero: use constant 0 as base |
| base_scalar_i | input | 1 | Base operand is scalar (enables element stride) |
| disp_i | input | 16 | Signed displacement |
| size_i | input | 4 | Access size in bytes (4 word, 8 doubleword) |
| vl_i | input | 7 | Vector length, 0..127 |
| mode_i | input | 2 | 00 unit, 01 element, 10 shifted, 11 unit |
| bitrev_i | input | 1 | Use bit-reversed element positions |
| shift_i | input | 6 | Left shift for shifted mode |
| addr_valid_o | output | 1 | Address valid |
| addr_ready_i | input | 1 | Consumer accepts address |
| addr_o | output | 64 | Effective address |
| addr_idx_o | output | 7 | Logical element number of the address |
| done_o | output | 1 | Sequence complete pulse |
| err_o | output | 1 | Bit reversal requested with non-power-of-two VL |

## Verification
Two situations are the hardest to reach from the ports. The first is a start strobe that arrives during a sequence while the consumer is stalling. The second is a last element whose handshake is delayed over several cycles, so the done pulse must wait for it. The bench reaches both by driving ready low at random about a quarter of the time. In the same runs it raises start with a corrupted base in the middle of a sequence. The stream must still match the operands captured at the first start. Directed runs cover the fallback conditions of element stride, bit reversal at VL of 4 and 8, rejected lengths, VL of zero and an address that wraps past 2^64.

// File: rtl/vea_pkg.sv
package vea_pkg;

    localparam int ADDR_W = 64;
    localparam int VL_W   = 7;
    localparam int DISP_W = 16;
    localparam int SIZE_W = 4;
    localparam int SH_W   = 6;

    typedef enum logic [1:0] {
        MODE_UNIT  = 2'd0,
        MODE_ELEM  = 2'd1,
        MODE_SHIFT = 2'd2,
        MODE_RSVD  = 2'd3
    } vea_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_ZERO = 2'd2,
        ST_ERR  = 2'd3
    } vea_state_e;

    // Per-operation operands, captured once at start.
    typedef struct packed {
        logic [ADDR_W-1:0] base_term;   // base or 0
        logic [ADDR_W-1:0] const_term;  // fixed offset added to every element
        logic [ADDR_W-1:0] step;        // multiplied by element position
        logic [SH_W-1:0]   shamt;       // left shift of the scaled term
        logic              brv;         // bit-reversed positions
        logic [VL_W-1:0]   vl;
        logic [VL_W-1:0]   levels;      // log2(vl) when vl is a power of two
    } vea_cfg_t;

    function automatic logic f_pow2(input logic [VL_W-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction

    function automatic logic [VL_W-1:0] f_levels(input logic [VL_W-1:0] v);
        logic [VL_W-1:0] r;
        r = '0;
        for (int k = 0; k < VL_W; k++) begin
            if (v[k]) r = VL_W'(k);
        end
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] f_sext(input logic [DISP_W-1:0] d);
        return {{(ADDR_W-DISP_W){d[DISP_W-1]}}, d};
    endfunction

endpackage

// File: rtl/vea_cfg_decode.sv
module vea_cfg_decode
    import vea_pkg::*;
(
    input  logic [ADDR_W-1:0] base_i,
    input  logic              base_zero_i,
    input  logic              base_scalar_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [1:0]        mode_i,
    input  logic              bitrev_i,
    input  logic [SH_W-1:0]   shift_i,
    output vea_cfg_t          cfg_o,
    output logic              bad_o
);
    vea_mode_e         mode;
    logic              elem_ok;
    logic [ADDR_W-1:0] dsx;
    logic [ADDR_W-1:0] sz;

    assign mode    = vea_mode_e'(mode_i);
    assign elem_ok = base_scalar_i && (disp_i != '0);
    assign dsx     = f_sext(disp_i);
    assign sz      = ADDR_W'(size_i);
    assign bad_o   = bitrev_i && (vl_i != '0) && !f_pow2(vl_i);

    always_comb begin
        cfg_o            = '0;
        cfg_o.base_term  = base_zero_i ? '0 : base_i;
        cfg_o.brv        = bitrev_i;
        cfg_o.vl         = vl_i;
        cfg_o.levels     = f_levels(vl_i);
        case (mode)
            MODE_ELEM: begin
                if (elem_ok) begin
                    cfg_o.step       = dsx;
                end else begin
                    cfg_o.const_term = dsx;
                    cfg_o.step       = sz;
                end
            end
            MODE_SHIFT: begin
                cfg_o.step  = dsx * sz;
                cfg_o.shamt = shift_i;
            end
            default: begin
                cfg_o.const_term = dsx;
                cfg_o.step       = sz;
            end
        endcase
    end
endmodule

// File: rtl/vea_index_gen.sv
module vea_index_gen
    import vea_pkg::*;
#(
    parameter int CW = VL_W
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          adv_i,
    input  logic          brv_i,
    input  logic [CW-1:0] levels_i,
    input  logic [CW-1:0] vl_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] pos_o,
    output logic          last_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] rev_full;
    logic [CW-1:0] rev_sh;

    always_ff @(posedge clk) begin
        if (rst || clr_i) cnt_q <= '0;
        else if (adv_i)   cnt_q <= cnt_q + 1'b1;
    end

    for (genvar k = 0; k < CW; k++) begin : g_rev
        assign rev_full[k] = cnt_q[CW-1-k];
    end

    assign rev_sh = CW'(CW) - levels_i;
    assign cnt_o  = cnt_q;
    assign pos_o  = brv_i ? (rev_full >> rev_sh) : cnt_q;
    assign last_o = (cnt_q == vl_i - 1'b1);
endmodule

// File: rtl/vea_addr_calc.sv
module vea_addr_calc
    import vea_pkg::*;
(
    input  vea_cfg_t          cfg_i,
    input  logic [VL_W-1:0]   pos_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] scaled;

    assign scaled = (cfg_i.step * ADDR_W'(pos_i)) << cfg_i.shamt;
    assign addr_o = cfg_i.base_term + cfg_i.const_term + scaled;
endmodule

// File: rtl/vec_ea_seq.sv
module vec_ea_seq
    import vea_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              base_zero_i,
    input  logic              base_scalar_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [VL_W-1:0]   vl_i,
    input  logic [1:0]        mode_i,
    input  logic              bitrev_i,
    input  logic [SH_W-1:0]   shift_i,
    output logic              addr_valid_o,
    input  logic              addr_ready_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [VL_W-1:0]   addr_idx_o,
    output logic              done_o,
    output logic              err_o
);
    vea_state_e      st_q;
    vea_cfg_t        cfg_d, cfg_q;
    logic            bad;
    logic            accept;
    logic            fire;
    logic            last;
    logic [VL_W-1:0] pos;

    vea_cfg_decode u_dec (
        .base_i        (base_i),
        .base_zero_i   (base_zero_i),
        .base_scalar_i (base_scalar_i),
        .disp_i        (disp_i),
        .size_i        (size_i),
        .vl_i          (vl_i),
        .mode_i        (mode_i),
        .bitrev_i      (bitrev_i),
        .shift_i       (shift_i),
        .cfg_o         (cfg_d),
        .bad_o         (bad)
    );

    assign accept = (st_q == ST_IDLE) && start_i;
    assign fire   = (st_q == ST_RUN) && addr_ready_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cfg_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cfg_q <= cfg_d;
                        if (vl_i == '0) st_q <= ST_ZERO;
                        else if (bad)   st_q <= ST_ERR;
                        else            st_q <= ST_RUN;
                    end
                end
                ST_RUN:  if (fire && last) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    vea_index_gen #(.CW(VL_W)) u_idx (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (accept),
        .adv_i    (fire),
        .brv_i    (cfg_q.brv),
        .levels_i (cfg_q.levels),
        .vl_i     (cfg_q.vl),
        .cnt_o    (addr_idx_o),
        .pos_o    (pos),
        .last_o   (last)
    );

    vea_addr_calc u_calc (
        .cfg_i  (cfg_q),
        .pos_i  (pos),
        .addr_o (addr_o)
    );

    assign addr_valid_o = (st_q == ST_RUN);
    assign done_o       = (st_q == ST_ZERO) || (fire && last);
    assign err_o        = (st_q == ST_ERR);
endmodule

// File: rtl/vea_checker.sv
module vea_checker
    import vea_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              valid,
    input logic              ready,
    input logic              done,
    input logic              err,
    input logic [ADDR_W-1:0] addr,
    input logic [VL_W-1:0]   idx
);
    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |=> valid && $stable(addr) && $stable(idx)); // R7

    AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        valid && ready && !done |=> valid && (idx == VL_W'($past(idx) + 1'b1))); // R7

    AST_FIRST_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> idx == '0); // R7

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
        err |-> !valid && !done); // R6

    AST_DONE_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
        done && valid |-> ready); // R8

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        done |=> !valid); // R8
endmodule

bind vec_ea_seq vea_checker u_chk (
    .clk   (clk),
    .rst   (rst),
    .valid (addr_valid_o),
    .ready (addr_ready_i),
    .done  (done_o),
    .err   (err_o),
    .addr  (addr_o),
    .idx   (addr_idx_o)
);

// File: tb/tb_vec_ea_seq.sv
`timescale 1ns/1ps
module tb_vec_ea_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [63:0] base_i = '0;
    logic        base_zero_i = 1'b0;
    logic        base_scalar_i = 1'b0;
    logic [15:0] disp_i = '0;
    logic [3:0]  size_i = '0;
    logic [6:0]  vl_i = '0;
    logic [1:0]  mode_i = '0;
    logic        bitrev_i = 1'b0;
    logic [5:0]  shift_i = '0;
    logic        addr_valid_o;
    logic        addr_ready_i = 1'b0;
    logic [63:0] addr_o;
    logic [6:0]  addr_idx_o;
    logic        done_o;
    logic        err_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    vec_ea_seq dut (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int lvls(input int vl);
        int l = 0;
        while ((1 << l) < vl) l++;
        return l;
    endfunction

    function automatic bit is_pow2(input int vl);
        return (vl != 0) && ((vl & (vl - 1)) == 0);
    endfunction

    function automatic logic [63:0] exp_addr(input logic [63:0] b, input bit bz, input bit sc,
            input logic [15:0] d, input logic [3:0] sz, input int vl, input logic [1:0] m,
            input bit br, input logic [5:0] sh, input int i);
        logic [63:0] bt, sx, s, p;
        int j, l;
        bt = bz ? 64'd0 : b;
        sx = {{48{d[15]}}, d};
        s  = {60'd0, sz};
        j  = i;
        if (br) begin
            l = lvls(vl);
            j = 0;
            for (int k = 0; k < l; k++) if (i[k]) j |= (1 << (l - 1 - k));
        end
        p = 64'(j);
        if (m == 2'b01 && sc && d != 16'd0) return bt + sx * p;
        if (m == 2'b10) return bt + ((sx * s * p) << sh);
        return bt + sx + s * p;
    endfunction

    // Runs one operation; mid_start raises start with a corrupted base during the run.
    task automatic run_op(input string req, input logic [63:0] b, input bit bz, input bit sc,
            input logic [15:0] d, input logic [3:0] sz, input int vl, input logic [1:0] m,
            input bit br, input logic [5:0] sh, input bit mid_start, input int rdy_pct);
        int got = 0;
        int guard = 0;
        bit held = 0;
        logic [63:0] hold_a = '0;
        @(negedge clk);
        base_i = b; base_zero_i = bz; base_scalar_i = sc; disp_i = d; size_i = sz;
        vl_i = 7'(vl); mode_i = m; bitrev_i = br; shift_i = sh; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (vl == 0) begin
            #1;
            chk(done_o === 1'b1, "R9 done", 64'(done_o), 64'd1);
            chk(addr_valid_o === 1'b0, "R9 valid", 64'(addr_valid_o), 64'd0);
            @(negedge clk); #1;
            chk(done_o === 1'b0 && addr_valid_o === 1'b0, "R9 quiet", 64'(done_o), 64'd0);
            return;
        end
        if (br && !is_pow2(vl)) begin
            #1;
            chk(err_o === 1'b1, "R6 err", 64'(err_o), 64'd1);
            chk(addr_valid_o === 1'b0 && done_o === 1'b0, "R6 silent", 64'(addr_valid_o), 64'd0);
            @(negedge clk); #1;
            chk(err_o === 1'b0 && addr_valid_o === 1'b0 && done_o === 1'b0, "R6 after", 64'(err_o), 64'd0);
            return;
        end
        while (got < vl && guard < 8 * vl + 20) begin
            addr_ready_i = (($urandom % 100) < rdy_pct);
            if (mid_start && got == 1) begin
                start_i = 1'b1; base_i = ~b; vl_i = 7'd0;
            end else begin
                start_i = 1'b0;
            end
            #1;
            if (addr_valid_o) begin
                if (held) chk(addr_o === hold_a, "R7 hold", addr_o, hold_a);
                if (addr_ready_i) begin
                    chk(addr_o === exp_addr(b, bz, sc, d, sz, vl, m, br, sh, got), req, addr_o,
                        exp_addr(b, bz, sc, d, sz, vl, m, br, sh, got));
                    chk(addr_idx_o === 7'(got), "R7 idx", 64'(addr_idx_o), 64'(got));
                    chk(done_o === (got == vl - 1), "R8 done", 64'(done_o), 64'(got == vl - 1));
                    got++;
                    held = 0;
                end else begin
                    chk(done_o === 1'b0, "R8 early", 64'(done_o), 64'd0);
                    held = 1;
                    hold_a = addr_o;
                end
            end else begin
                chk(1'b0, "R7 valid", 64'(addr_valid_o), 64'd1);
            end
            @(negedge clk);
            guard++;
        end
        start_i = 1'b0;
        addr_ready_i = 1'b0;
        chk(got == vl, "R7 count", 64'(got), 64'(vl));
        #1;
        chk(addr_valid_o === 1'b0, mid_start ? "R10 no restart" : "R7 end", 64'(addr_valid_o), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(addr_valid_o === 1'b0 && done_o === 1'b0 && err_o === 1'b0, "R7 reset",
            {61'd0, addr_valid_o, done_o, err_o}, 64'd0);

        run_op("R2 elem",      64'h10, 0, 1, 16'd24, 4'd4, 2, 2'b01, 0, 6'd0, 0, 100);
        chk(exp_addr(64'h10, 0, 1, 16'd24, 4'd4, 2, 2'b01, 0, 6'd0, 1) == 64'h28, "R2 example",
            exp_addr(64'h10, 0, 1, 16'd24, 4'd4, 2, 2'b01, 0, 6'd0, 1), 64'h28);
        run_op("R2 d0 fallback", 64'h100, 0, 1, 16'd0, 4'd8, 5, 2'b01, 0, 6'd0, 0, 70);
        run_op("R2 vec fallback", 64'h100, 0, 0, 16'd12, 4'd4, 5, 2'b01, 0, 6'd0, 0, 70);
        run_op("R2 rsvd mode", 64'h200, 0, 1, 16'hFFF0, 4'd2, 3, 2'b11, 0, 6'd0, 0, 100);
        run_op("R1 unit word", 64'h10, 0, 0, 16'd8, 4'd4, 4, 2'b00, 0, 6'd0, 0, 100);
        run_op("R1 unit neg",  64'h1000, 0, 0, 16'hFF00, 4'd8, 6, 2'b00, 0, 6'd0, 0, 60);
        run_op("R3 base zero", 64'hDEAD_BEEF_0000_1234, 1, 1, 16'd40, 4'd4, 3, 2'b01, 0, 6'd0, 0, 100);
        run_op("R4 shifted",   64'h10, 0, 1, 16'd3, 4'd4, 4, 2'b10, 0, 6'd2, 0, 80);
        run_op("R5 rev4",      64'h10, 0, 0, 16'd0, 4'd4, 4, 2'b00, 1, 6'd0, 0, 100);
        run_op("R5 rev8 shift", 64'h40, 0, 1, 16'd1, 4'd8, 8, 2'b10, 1, 6'd1, 0, 75);
        run_op("R5 rev64",     64'h0, 0, 1, 16'd2, 4'd4, 64, 2'b10, 1, 6'd0, 0, 90);
        run_op("R5 rev1",      64'h80, 0, 1, 16'd5, 4'd4, 1, 2'b01, 1, 6'd0, 0, 100);
        run_op("R6",           64'h10, 0, 0, 16'd4, 4'd4, 6, 2'b00, 1, 6'd0, 0, 100);
        run_op("R6",           64'h10, 0, 0, 16'd4, 4'd4, 3, 2'b10, 1, 6'd0, 0, 100);
        run_op("R9",           64'h10, 0, 0, 16'd4, 4'd4, 0, 2'b00, 1, 6'd0, 0, 100);
        run_op("R10 start ignored", 64'h300, 0, 1, 16'd16, 4'd4, 6, 2'b01, 0, 6'd0, 1, 50);
        run_op("R11 wrap",     64'hFFFF_FFFF_FFFF_FFF8, 0, 0, 16'd0, 4'd8, 3, 2'b00, 0, 6'd0, 0, 100);
        run_op("R11 wrap shift", 64'hFFFF_FFFF_FFFF_FF00, 0, 1, 16'h7FFF, 4'd8, 4, 2'b10, 0, 6'd50, 0, 100);

        for (int n = 0; n < 60; n++) begin
            logic [1:0] m;
            int vl;
            m  = 2'($urandom % 4);
            vl = $urandom % 21;
            run_op("R1/R2/R4 random", {$urandom, $urandom}, ($urandom % 5) == 0, $urandom % 2,
                   16'($urandom), 4'(1 << ($urandom % 4)), vl, m, ($urandom % 3) == 0,
                   6'($urandom % 8), ($urandom % 4) == 0, 40 + ($urandom % 61));
        end

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule